// File: doc/BRIEF.md
# Adaptive Long/Short Frame-Sync PCM Serial Port

This block is the serial side of a voiceband codec. In each direction it moves one 8-bit companded sample per frame. The transmit and receive sections each have their own bit clock and frame sync, and the two may be wired together. The port measures the width of every sync pulse by counting bit-clock falling edges that see the sync high. That class decides the framing of the following frame: either the word is aligned to the sync's rising edge, or it starts one bit after the edge that caught a one-bit sync.

All pins are sampled in the fabric clock domain and their edges are detected there, so the block runs on a single clock. The transmit pin is meant for a tri-state pad. Its enable is released at the exact point the framing rules call for. After reset, and after every power-down, the enable is held off for two full frame periods so that the port cannot collide with another driver on the bus. A received byte is presented with a one-cycle strobe.

Top module: `pcm_fsync_port`

## Requirements
- R1: A sync pulse that is high at two or more consecutive bit-clock falling edges is classed long.
- R2: A sync pulse that is high at exactly one bit-clock falling edge is classed short.
- R3: Each frame uses the class measured on the previous sync pulse of the same direction. A pulse of a different width changes the framing only from the next frame onward.
- R4: Short framing, transmit: the MSB is launched and tx_oe rises on the first bit-clock rising edge after the falling edge that caught the sync. The remaining bits follow MSB first, one per rising edge.
- R5: Long framing, transmit: the MSB is launched and tx_oe rises at the sync rising edge. The remaining bits follow MSB first on rising edges, and tx_oe stays high for as long as the sync stays high.
- R6: tx_oe falls at the later of two events: the sync falling, and the 8th bit-clock falling edge of the word (the middle of the LSB). In short framing this is the 8th falling edge after the catching edge. In long framing the catching edge counts as the first.
- R7: After reset or power-up, tx_oe stays low through the first two frames (first two transmit sync rising edges). Transmission resumes from the third frame.
- R8: Receive bits are sampled MSB first on bit-clock falling edges. In short framing these are the 8 falling edges after the catching edge. In long framing they are the catching edge and the 7 after it.
- R9: rx_valid is high for exactly one clock once the 8th bit is captured, with rx_word holding the byte (first bit received in bit 7).
- R10: While pwr_up is low, tx_oe, tx_sdata and rx_valid stay low whatever the pins do.
- R11: After reset or power-up, before any pulse has been measured, the framing is short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up | input | 1 | High = powered, low = powered down |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| tx_word | input | 8 | Byte to send in the coming frame |
| tx_sdata | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output enable for the transmit pad |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_sdata | input | 1 | Serial receive data |
| rx_word | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_word |

## Verification
The hardest situation to reach is a frame whose sync width disagrees with the framing in force. A long pulse must still be served with short timing, and a one-edge pulse with long timing, because the class only applies from the next frame. The stimulus reaches this by sending sequences of frames with chosen pulse widths: short, short, then long, then long again, then a single-edge pulse. The byte on the pins is compared against the timing the previous pulse implies. The power-down sequence is used to check the default framing: the first frame after power-up carries a long pulse and must still be read with short timing.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {FK_SHORT = 1'b0, FK_LONG = 1'b1} frame_kind_e;
endpackage

// File: rtl/pcm_pin_sync.sv
module pcm_pin_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl  = lvl_q;
  assign rise = lvl_q & ~prev_q;
  assign fall = ~lvl_q & prev_q;
endmodule

// File: rtl/pcm_framer.sv
module pcm_framer
  import pcm_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bclk_rise,
  input  logic                 bclk_fall,
  input  logic                 sync_lvl,
  input  logic                 sync_rise,
  input  logic                 sync_fall,
  output frame_kind_e          cur_kind,
  output logic                 drv_stb,
  output logic                 drv_first,
  output logic                 smp_stb,
  output logic                 smp_last
);
  localparam int CNT_W = $clog2(W + 2);

  logic [CNT_W-1:0] fcnt;
  logic [1:0]       hi_falls;
  logic             in_frame;
  frame_kind_e      next_kind;
  logic [CNT_W-1:0] off_v, rel;
  logic             in_win;

  assign off_v  = (cur_kind == FK_SHORT) ? CNT_W'(1) : CNT_W'(0);
  assign rel    = fcnt - off_v;
  assign in_win = in_frame && (fcnt >= off_v) && (rel < CNT_W'(W));

  assign smp_stb  = bclk_fall && in_win;
  assign smp_last = smp_stb && (rel == CNT_W'(W - 1));

  // Long framing launches the MSB at the sync edge itself.
  assign drv_stb   = (sync_rise && next_kind == FK_LONG) ||
                     (bclk_rise && !sync_rise && in_win);
  assign drv_first = sync_rise || (rel == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt      <= '0;
      hi_falls  <= '0;
      in_frame  <= 1'b0;
      next_kind <= FK_SHORT;
      cur_kind  <= FK_SHORT;
    end else begin
      if (sync_rise) begin
        fcnt     <= '0;
        in_frame <= 1'b1;
        cur_kind <= next_kind;
      end else if (bclk_fall && in_frame) begin
        fcnt <= fcnt + CNT_W'(1);
        if (smp_last) in_frame <= 1'b0;
      end

      if (sync_rise)
        hi_falls <= '0;
      else if (bclk_fall && sync_lvl && hi_falls != 2'd2)
        hi_falls <= hi_falls + 2'd1;

      if (sync_fall)
        next_kind <= (hi_falls == 2'd2) ? FK_LONG : FK_SHORT;
    end
  end
endmodule

// File: rtl/pcm_fsync_port.sv
module pcm_fsync_port
  import pcm_port_pkg::*;
#(
  parameter int W     = 8,
  parameter int GUARD = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwr_up,
  input  logic         tx_bclk,
  input  logic         tx_fsync,
  input  logic [W-1:0] tx_word,
  output logic         tx_sdata,
  output logic         tx_oe,
  input  logic         rx_bclk,
  input  logic         rx_fsync,
  input  logic         rx_sdata,
  output logic [W-1:0] rx_word,
  output logic         rx_valid
);
  localparam int GW = $clog2(GUARD + 1);
  localparam int NL = 2;  // lane 0 transmit, lane 1 receive

  logic          pwr_q, lane_rst;
  logic [2:0]    pin_bus [NL];
  logic [2:0]    p_lvl [NL], p_rise [NL], p_fall [NL];
  frame_kind_e   kind [NL];
  logic          drv_stb [NL], drv_first [NL], smp_stb [NL], smp_last [NL];

  always_ff @(posedge clk) begin
    if (rst) pwr_q <= 1'b0;
    else     pwr_q <= pwr_up;
  end
  assign lane_rst = rst || !pwr_q;

  assign pin_bus[0] = {1'b0, tx_fsync, tx_bclk};
  assign pin_bus[1] = {rx_sdata, rx_fsync, rx_bclk};

  for (genvar g = 0; g < NL; g++) begin : g_lane
    pcm_pin_sync #(.WIDTH(3)) u_sync (
      .clk(clk), .rst(lane_rst), .pins(pin_bus[g]),
      .lvl(p_lvl[g]), .rise(p_rise[g]), .fall(p_fall[g])
    );
    pcm_framer #(.W(W)) u_frm (
      .clk(clk), .rst(lane_rst),
      .bclk_rise(p_rise[g][0]), .bclk_fall(p_fall[g][0]),
      .sync_lvl(p_lvl[g][1]), .sync_rise(p_rise[g][1]), .sync_fall(p_fall[g][1]),
      .cur_kind(kind[g]), .drv_stb(drv_stb[g]), .drv_first(drv_first[g]),
      .smp_stb(smp_stb[g]), .smp_last(smp_last[g])
    );
  end

  // Transmit side
  logic          tx_sync_lvl, rx_fall;
  logic [GW-1:0] guard_cnt;
  logic          guard_ok, frame_en, tx_done;
  logic [W-1:0]  tx_hold;

  assign tx_sync_lvl = p_lvl[0][1];
  assign rx_fall     = p_fall[1][0];
  assign guard_ok    = (guard_cnt == GW'(GUARD));

  always_ff @(posedge clk) begin
    if (lane_rst) begin
      guard_cnt <= '0;
      frame_en  <= 1'b0;
      tx_done   <= 1'b0;
      tx_hold   <= '0;
      tx_sdata  <= 1'b0;
      tx_oe     <= 1'b0;
    end else begin
      if (p_rise[0][1]) begin
        frame_en <= guard_ok;
        tx_done  <= 1'b0;
        if (!guard_ok) guard_cnt <= guard_cnt + GW'(1);
      end else if (smp_last[0]) begin
        tx_done <= 1'b1;
      end

      if (drv_stb[0] && drv_first[0] && (p_rise[0][1] ? guard_ok : frame_en)) begin
        tx_oe    <= 1'b1;
        tx_sdata <= tx_word[W-1];
        tx_hold  <= tx_word << 1;
      end else if ((smp_last[0] || tx_done) && !tx_sync_lvl) begin
        tx_oe    <= 1'b0;
        tx_sdata <= 1'b0;
      end else if (drv_stb[0] && tx_oe) begin
        tx_sdata <= tx_hold[W-1];
        tx_hold  <= tx_hold << 1;
      end
    end
  end

  // Receive side
  logic [W-1:0] rx_shift;

  always_ff @(posedge clk) begin
    if (lane_rst) begin
      rx_shift <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (smp_stb[1]) begin
        rx_shift <= {rx_shift[W-2:0], p_lvl[1][2]};
        if (smp_last[1]) begin
          rx_word  <= {rx_shift[W-2:0], p_lvl[1][2]};
          rx_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_fsync_port_chk.sv
module pcm_fsync_port_chk #(
  parameter int W     = 8,
  parameter int GUARD = 2,
  localparam int GW   = $clog2(GUARD + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          pwr_up,
  input logic          pwr_q,
  input logic [GW-1:0] guard_cnt,
  input logic          tx_oe,
  input logic          tx_sdata,
  input logic          tx_sync_lvl,
  input logic          rx_valid,
  input logic          rx_fall
);
  AST_OE_AFTER_GUARD: assert property (@(posedge clk) disable iff (rst)
    tx_oe |-> guard_cnt == GW'(GUARD)); // R7
  AST_OE_HELD_BY_SYNC: assert property (@(posedge clk) disable iff (rst || !pwr_up || !pwr_q)
    (tx_oe && tx_sync_lvl) |=> tx_oe); // R5
  AST_PD_SILENT: assert property (@(posedge clk) disable iff (rst)
    !pwr_q |=> (!tx_oe && !tx_sdata && !rx_valid)); // R10
  AST_VALID_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(rx_fall)); // R8
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R9
endmodule

bind pcm_fsync_port pcm_fsync_port_chk #(.W(W), .GUARD(GUARD)) u_chk (
  .clk(clk), .rst(rst), .pwr_up(pwr_up), .pwr_q(pwr_q), .guard_cnt(guard_cnt),
  .tx_oe(tx_oe), .tx_sdata(tx_sdata), .tx_sync_lvl(tx_sync_lvl),
  .rx_valid(rx_valid), .rx_fall(rx_fall)
);

// File: tb/pcm_fsync_port_test.sv
module pcm_fsync_port_test;
  localparam int HALF = 12;
  localparam int NCYC = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_up = 1'b1;
  logic       bclk = 1'b0, fsync = 1'b0, sdin = 1'b0;
  logic [7:0] tx_word = 8'h00;
  logic       tx_sdata, tx_oe, rx_valid;
  logic [7:0] rx_word;

  int checks = 0, failures = 0, vcnt = 0;
  logic [7:0] vword = 8'h00;
  bit finished = 0;

  always #10 clk = ~clk;

  pcm_fsync_port uut (
    .clk(clk), .rst(rst), .pwr_up(pwr_up),
    .tx_bclk(bclk), .tx_fsync(fsync), .tx_word(tx_word),
    .tx_sdata(tx_sdata), .tx_oe(tx_oe),
    .rx_bclk(bclk), .rx_fsync(fsync), .rx_sdata(sdin),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  always @(posedge clk) if (!rst && rx_valid) begin
    vcnt  <= vcnt + 1;
    vword <= rx_word;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One frame; e_long gives the framing the port is expected to apply.
  task automatic run_frame(input int L, input bit e_long, input bit exp_oe,
                           input bit exp_rx, input logic [7:0] txb,
                           input logic [7:0] rxb, input string tag);
    logic sd [NCYC], oef [NCYC], oer [NCYC];
    logic [7:0] got;
    int   last;
    tx_word = txb;
    @(negedge clk);
    vcnt = 0;
    for (int c = 0; c < NCYC; c++) begin
      bclk  = 1'b1;
      fsync = (c < L);
      if (e_long) sdin = (c < 8) ? rxb[7-c] : 1'b0;
      else        sdin = (c >= 1 && c <= 8) ? rxb[8-c] : 1'b0;
      repeat (HALF - 1) @(negedge clk);
      sd[c] = tx_sdata; oef[c] = tx_oe;
      @(negedge clk);
      bclk = 1'b0;
      repeat (HALF) @(negedge clk);
      oer[c] = tx_oe;
    end
    if (exp_oe) begin
      for (int k = 0; k < 8; k++) got[7-k] = e_long ? sd[k] : sd[k+1];
      chk(got == txb, e_long ? "R5 long tx byte" : "R4 short tx byte", got, txb);
      if (e_long) chk(oef[0] == 1'b1, "R5 oe at sync rise", oef[0], 1);
      else chk(oef[0] == 1'b0 && oef[1] == 1'b1, "R4 oe after catching edge",
               {oef[0], oef[1]}, 1);
      if (e_long) begin
        last = (L > 8) ? L : 8;
        chk(oer[7] == (L > 8) && oef[last] == 1'b0, "R6 long oe release",
            {oer[7], oef[last]}, (L > 8) ? 2 : 0);
        if (L > 8) chk(oer[L-1] == 1'b1, "R5 oe held while sync high", oer[L-1], 1);
      end else begin
        chk(oer[7] == 1'b1 && oer[8] == 1'b0, "R6 short oe release", {oer[7], oer[8]}, 2);
      end
    end else begin
      got = 8'h00;
      for (int c = 0; c < NCYC; c++) if (oef[c] || oer[c]) got = 8'h01;
      chk(got == 8'h00, tag, got, 0);
    end
    if (exp_rx)
      chk(vcnt == 1 && vword == rxb, e_long ? "R8 R9 long rx byte" : "R8 R9 short rx byte",
          {vcnt[7:0], vword}, {8'h01, rxb});
    else
      chk(vcnt == 0, "R10 no rx strobe", vcnt, 0);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_oe == 1'b0 && tx_sdata == 1'b0 && rx_valid == 1'b0, "R10 reset state",
        {tx_oe, tx_sdata, rx_valid}, 0);
  endtask

  task automatic t_startup;
    // R7: two guarded frames, then short framing by default (R11)
    run_frame(1, 1'b0, 1'b0, 1'b1, 8'hA5, 8'h3C, "R7 guard frame 1");
    run_frame(1, 1'b0, 1'b0, 1'b1, 8'h5A, 8'hC3, "R7 guard frame 2");
    run_frame(1, 1'b0, 1'b1, 1'b1, 8'h96, 8'h81, "R4");
  endtask

  task automatic t_class_switch;
    // R3: long pulse still served short; R1 then long applies
    run_frame(3, 1'b0, 1'b1, 1'b1, 8'hE1, 8'h7E, "R3");
    run_frame(3, 1'b1, 1'b1, 1'b1, 8'h4B, 8'hD2, "R1");
    run_frame(12, 1'b1, 1'b1, 1'b1, 8'h0F, 8'hF0, "R5");
    // R3: single-edge pulse still served long; R2 then short applies
    run_frame(1, 1'b1, 1'b1, 1'b1, 8'h81, 8'h18, "R3");
    run_frame(1, 1'b0, 1'b1, 1'b1, 8'h7F, 8'h01, "R2");
  endtask

  task automatic t_power_cycle;
    pwr_up = 1'b0;
    run_frame(1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hAA, "R10 oe during power-down");
    pwr_up = 1'b1;
    // R11: long pulse after power-up is read with short timing
    run_frame(3, 1'b0, 1'b0, 1'b1, 8'h33, 8'h6D, "R7 guard after power-up 1");
    run_frame(1, 1'b1, 1'b0, 1'b1, 8'h44, 8'hB6, "R7 guard after power-up 2");
    run_frame(1, 1'b0, 1'b1, 1'b1, 8'hC9, 8'h27, "R7");
  endtask

  initial begin
    t_reset();
    t_startup();
    t_class_switch();
    t_power_cycle();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule